// File: doc/BRIEF.md
# Banked Serial Control Register File

This block is a four-wire serial slave that holds two banks of 10-bit control registers, a main bank and a local bank, each of 32 entries. A host shifts in 16-bit frames while the chip select is low. Each frame carries a read/write flag, a 5-bit register address and 10 data bits. A write takes effect when chip select returns high. A read shifts the addressed register back out on the serial data output. Every register value is also presented in parallel, so that the analog and control logic around the block can use it.

The 5-bit address is too narrow for 64 registers, so bit 0 of main register 0 chooses the bank. Address 0 always reaches main register 0, whatever that bit holds, so the host can always switch back. Two enable bits in main register 27 turn selected main-bank reads into live status reads. With the first enabled, a read of main address 21 returns a 3-bit revision code. With the second enabled, a read of main address 19 returns the tuning converter code together with the present oscillator sub-band.

Chip select, serial clock and serial data are resynchronised to the system clock and sampled there. The registers have no automatic power-up value. The only clear is a synchronous reset, which is provided for simulation.

Top module: `spi_bank_regfile`

## Requirements
- R1: A frame is shifted most significant bit first. Frame bit 15 is the direction (1 = read, 0 = write), bits 14:10 are the register address and bits 9:0 are the data.
- R2: A write frame that had exactly 16 serial clock rising edges while chip select was low stores its 10 data bits in the addressed register when chip select rises. The parallel output then shows the new value.
- R3: A frame with fewer or more than 16 rising edges changes no register.
- R4: In a read frame, the addressed register's bits 9 down to 0 are driven on the serial output after the falling edges that follow rising edges 6 through 15. The host samples them on rising edges 7 through 16. A read changes no register.
- R5: When main register 0 bit 0 is 1, addresses 1 to 31 reach the local bank for both writes and reads. When it is 0, they reach the main bank. Local writes leave the main bank unchanged.
- R6: Address 0 always reaches main register 0, in either bank state.
- R7: When main register 27 bit 9 is 1, a read of main address 21 returns the revision input in bits 7:5, with all other bits 0. When that bit is 0, the read returns the stored value.
- R8: When main register 27 bit 5 is 1, a read of main address 19 returns the tune code input in bits 8:6 and the sub-band input in bits 5:0, with bit 9 at 0.
- R9: Local-bank reads of addresses 19 and 21 always return stored values.
- R10: The synchronous reset clears all 64 registers to zero. The serial output is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and storage |
| rst | input | 1 | Synchronous reset, active high (simulation use) |
| spi_cs_n | input | 1 | Chip select, active low, frames a transfer |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data into the block |
| rev_id_i | input | 3 | Revision code for the status read |
| vco_band_i | input | 6 | Present oscillator sub-band |
| tune_code_i | input | 3 | Tuning converter code |
| spi_miso | output | 1 | Serial data out during reads |
| main_regs_o | output | 320 | Main bank, register n at bits 10n+9:10n |
| local_regs_o | output | 320 | Local bank, register n at bits 10n+9:10n |

## Verification
Two functions meet in the same commit cycle: a write to address 0 and the bank decode of that same write. The write changes the bank bit at the edge where its own destination is being chosen. The bench provokes this by writing address 0 with the bank bit already set, first to clear it and later to set it again. The outcome is judged through the parallel outputs: main register 0 must take the value and local register 0 must stay zero. A later access to address 3 must then land in the bank the new bit names.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;
    // status field layout inside a 10-bit read word
    localparam int REV_W    = 3;
    localparam int REV_LSB  = 5;
    localparam int BAND_W   = 6;
    localparam int BAND_LSB = 0;
    localparam int TUNE_W   = 3;
    localparam int TUNE_LSB = 6;

    // control positions
    localparam int CTRL_ADDR   = 27;
    localparam int REV_EN_BIT  = 9;
    localparam int TUNE_EN_BIT = 5;
    localparam int REV_ADDR    = 21;
    localparam int TUNE_ADDR   = 19;

    // address 0 is pinned to the main bank
    function automatic logic use_local(input int unsigned addr, input logic bank_bit);
        return bank_bit && (addr != 0);
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        stage_d[0] = pin_i;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic [REG_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              dout
);
    localparam int FRAME_W = 1 + ADDR_W + REG_W;
    localparam int HDR_W   = 1 + ADDR_W;
    localparam int CW      = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic [FRAME_W-1:0] shift;
        logic [HDR_W-1:0]   hdr;
        logic               dout;
        logic               cs_prev;
        logic               sclk_prev;
    } fr_t;

    fr_t fr_d, fr_q;
    logic cs_rise, sclk_rise, sclk_fall, in_data;
    logic [CW-1:0]    data_pos;
    logic [REG_W-1:0] rd_shifted;

    assign cs_rise   = cs_s & ~fr_q.cs_prev;
    assign sclk_rise = sclk_s & ~fr_q.sclk_prev;
    assign sclk_fall = ~sclk_s & fr_q.sclk_prev;
    assign data_pos  = CW'(FRAME_W - 1) - fr_q.cnt;
    assign rd_shifted = rd_data >> data_pos;
    assign in_data   = fr_q.hdr[HDR_W-1] && (fr_q.cnt >= CW'(HDR_W))
                       && (fr_q.cnt < CW'(FRAME_W));

    always_comb begin
        fr_d = fr_q;
        fr_d.cs_prev   = cs_s;
        fr_d.sclk_prev = sclk_s;
        if (cs_s) begin
            fr_d.cnt  = '0;
            fr_d.hdr  = '0;
            fr_d.dout = 1'b0;
        end else begin
            if (sclk_rise) begin
                fr_d.shift = {fr_q.shift[FRAME_W-2:0], din_s};
                if (fr_q.cnt < CW'(FRAME_W + 1)) fr_d.cnt = fr_q.cnt + 1'b1;
                if (fr_q.cnt == CW'(HDR_W - 1))
                    fr_d.hdr = {fr_q.shift[HDR_W-2:0], din_s};
            end
            if (sclk_fall) fr_d.dout = in_data ? rd_shifted[0] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fr_q <= '0;
        else     fr_q <= fr_d;
    end

    assign wr_en   = cs_rise && (fr_q.cnt == CW'(FRAME_W)) && !fr_q.shift[FRAME_W-1];
    assign wr_addr = fr_q.shift[FRAME_W-2 -: ADDR_W];
    assign wr_data = fr_q.shift[REG_W-1:0];
    assign rd_addr = fr_q.hdr[ADDR_W-1:0];
    assign dout    = fr_q.dout;

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !dout);                                        // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        fr_q.cnt <= CW'(FRAME_W + 1));                          // R3
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);                                      // R2
endmodule

// File: rtl/spi_bank_store.sv
module spi_bank_store
    import spi_bank_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int REG_W  = 10
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [REG_W-1:0]                wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    input  logic [REV_W-1:0]                rev_id,
    input  logic [BAND_W-1:0]               vco_band,
    input  logic [TUNE_W-1:0]               tune_code,
    output logic [REG_W-1:0]                rd_data,
    output logic [(1<<ADDR_W)*REG_W-1:0]    main_flat,
    output logic [(1<<ADDR_W)*REG_W-1:0]    local_flat
);
    localparam int NUM = 1 << ADDR_W;

    typedef struct packed {
        logic [NUM-1:0][REG_W-1:0] mn;
        logic [NUM-1:0][REG_W-1:0] lc;
    } bank_t;

    bank_t st_d, st_q;
    logic  bank_bit, wr_local, rd_local, rev_on, tune_on;

    assign bank_bit = st_q.mn[0][0];
    assign wr_local = use_local(int'(wr_addr), bank_bit);
    assign rd_local = use_local(int'(rd_addr), bank_bit);
    assign rev_on   = st_q.mn[CTRL_ADDR][REV_EN_BIT];
    assign tune_on  = st_q.mn[CTRL_ADDR][TUNE_EN_BIT];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_local) st_d.lc[wr_addr] = wr_data;
            else          st_d.mn[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        rd_data = rd_local ? st_q.lc[rd_addr] : st_q.mn[rd_addr];
        if (!rd_local && rev_on && rd_addr == ADDR_W'(REV_ADDR)) begin
            rd_data = '0;
            rd_data[REV_LSB +: REV_W] = rev_id;
        end
        if (!rd_local && tune_on && rd_addr == ADDR_W'(TUNE_ADDR)) begin
            rd_data = '0;
            rd_data[TUNE_LSB +: TUNE_W] = tune_code;
            rd_data[BAND_LSB +: BAND_W] = vco_band;
        end
    end

    assign main_flat  = st_q.mn;
    assign local_flat = st_q.lc;

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q));                              // R3
    AST_ADDR0_MAIN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0) |=> st_q.mn[0] == $past(wr_data)); // R6
    AST_LOCAL_SPARES_MAIN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bank_bit && wr_addr != '0) |=> $stable(st_q.mn)); // R5
endmodule

// File: rtl/spi_bank_regfile.sv
module spi_bank_regfile
    import spi_bank_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int REG_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         spi_cs_n,
    input  logic                         spi_sclk,
    input  logic                         spi_mosi,
    input  logic [REV_W-1:0]             rev_id_i,
    input  logic [BAND_W-1:0]            vco_band_i,
    input  logic [TUNE_W-1:0]            tune_code_i,
    output logic                         spi_miso,
    output logic [(1<<ADDR_W)*REG_W-1:0] main_regs_o,
    output logic [(1<<ADDR_W)*REG_W-1:0] local_regs_o
);
    logic [2:0]        pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [REG_W-1:0]  wr_data, rd_data;

    spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  ({spi_mosi, spi_sclk, spi_cs_n}),
        .sync_o (pins_s)
    );

    spi_frame_rx #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cs_s    (pins_s[0]),
        .sclk_s  (pins_s[1]),
        .din_s   (pins_s[2]),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .dout    (spi_miso)
    );

    spi_bank_store #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rev_id     (rev_id_i),
        .vco_band   (vco_band_i),
        .tune_code  (tune_code_i),
        .rd_data    (rd_data),
        .main_flat  (main_regs_o),
        .local_flat (local_regs_o)
    );
endmodule

// File: tb/spi_bank_regfile_tb.sv
`timescale 1ns/1ps
module spi_bank_regfile_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [2:0] rev = '0;
    logic [5:0] band = '0;
    logic [2:0] tune = '0;
    logic miso;
    logic [319:0] main_o, local_o;
    int vectors = 0, miscompares = 0;
    logic [9:0] rd;

    always #2.5 clk = ~clk;

    spi_bank_regfile dut_i (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .rev_id_i(rev), .vco_band_i(band), .tune_code_i(tune),
        .spi_miso(miso), .main_regs_o(main_o), .local_regs_o(local_o)
    );

    function automatic logic [9:0] mreg(input int n); return main_o[n*10 +: 10]; endfunction
    function automatic logic [9:0] lreg(input int n); return local_o[n*10 +: 10]; endfunction

    task automatic check(input string req, input logic [319:0] got, input logic [319:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic rw, input logic [4:0] a, input logic [9:0] d,
                        input int nbits, output logic [9:0] r);
        logic [15:0] f;
        f = {rw, a, d};
        r = '0;
        cs_n = 1'b0; #40;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = (i < 16) ? f[15-i] : 1'b0;
            #40;
            sclk = 1'b1;
            if (i >= 6 && i < 16) r[15-i] = miso;
            #40;
        end
        sclk = 1'b0; #40;
        cs_n = 1'b1; mosi = 1'b0; #100;
    endtask

    task automatic wr(input logic [4:0] a, input logic [9:0] d);
        logic [9:0] junk;
        xfer(1'b0, a, d, 16, junk);
    endtask

    task automatic t_reset;
        check("R10 main clear", main_o, '0);
        check("R10 local clear", local_o, '0);
        check("R10 miso idle", {319'b0, miso}, '0);
    endtask

    task automatic t_write_read;
        wr(5'd3, 10'h2A5);
        check("R1 R2 main3 written", mreg(3), 10'h2A5);
        wr(5'd31, 10'h3FF);
        check("R2 main31 written", mreg(31), 10'h3FF);
        xfer(1'b1, 5'd3, 10'h000, 16, rd);
        check("R4 read main3", rd, 10'h2A5);
        check("R4 read leaves main3", mreg(3), 10'h2A5);
        xfer(1'b1, 5'd31, 10'h155, 16, rd);
        check("R4 read main31", rd, 10'h3FF);
        check("R4 read data bits ignored", mreg(31), 10'h3FF);
        check("R10 miso low after frame", {319'b0, miso}, '0);
    endtask

    task automatic t_bad_length;
        xfer(1'b0, 5'd5, 10'h123, 15, rd);
        check("R3 short frame", mreg(5), 10'h000);
        xfer(1'b0, 5'd5, 10'h123, 17, rd);
        check("R3 long frame", mreg(5), 10'h000);
        check("R3 local untouched", local_o, '0);
    endtask

    task automatic t_bank;
        wr(5'd0, 10'h001);
        check("R5 bank bit set", mreg(0), 10'h001);
        wr(5'd3, 10'h155);
        check("R5 local3 written", lreg(3), 10'h155);
        check("R5 main3 kept", mreg(3), 10'h2A5);
        xfer(1'b1, 5'd3, 10'h000, 16, rd);
        check("R5 read local3", rd, 10'h155);
        wr(5'd0, 10'h000);
        check("R6 addr0 to main", mreg(0), 10'h000);
        check("R6 local0 untouched", lreg(0), 10'h000);
        xfer(1'b1, 5'd3, 10'h000, 16, rd);
        check("R5 back to main3", rd, 10'h2A5);
    endtask

    task automatic t_status;
        wr(5'd21, 10'h3C3);
        wr(5'd19, 10'h0F0);
        xfer(1'b1, 5'd21, 10'h000, 16, rd);
        check("R7 stored when disabled", rd, 10'h3C3);
        rev = 3'b101;
        wr(5'd27, 10'h200);
        xfer(1'b1, 5'd21, 10'h000, 16, rd);
        check("R7 revision read", rd, 10'h0A0);
        check("R7 stored value kept", mreg(21), 10'h3C3);
        xfer(1'b1, 5'd19, 10'h000, 16, rd);
        check("R8 stored when disabled", rd, 10'h0F0);
        tune = 3'b110; band = 6'h2B;
        wr(5'd27, 10'h020);
        xfer(1'b1, 5'd19, 10'h000, 16, rd);
        check("R8 tune and band read", rd, 10'h1AB);
        xfer(1'b1, 5'd21, 10'h000, 16, rd);
        check("R7 stored after disable", rd, 10'h3C3);
    endtask

    task automatic t_local_status;
        wr(5'd27, 10'h220);
        wr(5'd0, 10'h001);
        wr(5'd21, 10'h111);
        wr(5'd19, 10'h222);
        xfer(1'b1, 5'd21, 10'h000, 16, rd);
        check("R9 local21 stored", rd, 10'h111);
        xfer(1'b1, 5'd19, 10'h000, 16, rd);
        check("R9 local19 stored", rd, 10'h222);
        wr(5'd0, 10'h000);
        xfer(1'b1, 5'd21, 10'h000, 16, rd);
        check("R7 main21 override", rd, 10'h0A0);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #10;
        check("R10 reset clears main", main_o, '0);
        check("R10 reset clears local", local_o, '0);
    endtask

    initial begin
        #50 rst = 1'b0;
        #50;
        t_reset();
        t_write_read();
        t_bad_length();
        t_bank();
        t_status();
        t_local_status();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule